// File: doc/BRIEF.md
# I2C Controller Clock and Data Pacer

This block produces the serial clock for an I2C controller and decides the instant at which the data line may move. It runs from one kernel clock. Each bit goes through a fixed cycle. The block pulls the clock low and waits a programmable hold delay. It then puts the next data bit on the data drive. After a programmable setup delay, and once a programmable low count has run out, it releases the clock. It waits until the clock line is actually seen high, times a programmable high count, and pulses a bit-done strobe.

All delays are counted in prescaled time units of (prescale + 1) kernel clocks. The low and high counts start only after the new bus level has come back through a two-stage input synchronizer. The real clock period is therefore longer than the programmed low time plus high time. The same wait lets another device stretch the clock: the high count does not start while the line is still held low.

Both drives are open-drain enables, where 1 means pull the line low. The configuration fields are captured at the start of every bit. Dropping the enable releases both lines and clears every counter within one clock. START/STOP generation, addressing, acknowledge handling and byte framing belong to the surrounding controller.

Top module: `scl_pacer`

States: `ST_IDLE` (both lines released), `ST_PULL` (clock pulled, waiting to see it low), `ST_HOLD` (hold delay), `ST_SETUP` (setup delay), `ST_LOWREST` (rest of the low count), `ST_RELEASE` (clock released, waiting to see it high), `ST_HIGH` (high count).

Transitions:
- IDLE→PULL when enabled.
- PULL→HOLD on the synchronized line reading low.
- HOLD→SETUP when the hold delay expires. This transition also updates SDA.
- SETUP→RELEASE when the setup delay expires and the low count has already expired.
- SETUP→LOWREST when the setup delay expires and the low count has not.
- LOWREST→RELEASE when the low count expires.
- RELEASE→HIGH on the synchronized line reading high.
- HIGH→PULL on expiry of the high count, which also strobes bit-done.
- Any state→IDLE when the enable is low.

## Requirements
- R1: While `en` is low, and from reset, `scl_pull`, `sda_pull` and `bit_done` are 0. Lowering `en` in any state releases both lines one clock later and clears all counters.
- R2: With P = `cfg_presc`, the clock stays pulled for (`cfg_low`+1)·(P+1)+4 kernel clocks, provided this exceeds the data-path bound of R5.
- R3: With no stretching, once `scl_pull` drops, the next bit's `scl_pull` assertion follows after (`cfg_high`+1)·(P+1)+4 kernel clocks.
- R4: `sda_pull` takes the value NOT `data_bit` exactly `cfg_hold`·(P+1)+4 kernel clocks after `scl_pull` rises. A hold value of 0 adds no units.
- R5: The clock is never released earlier than (`cfg_hold`+`cfg_setup`+1)·(P+1)+5 kernel clocks after `scl_pull` rises. The low time is the larger of this and the R2 value.
- R6: `sda_pull` changes only while `scl_pull` is asserted, apart from the release forced by R1.
- R7: `bit_done` is a single-cycle pulse at the end of each high phase. When `en` is high, `scl_pull` is asserted in the following cycle.
- R8: While another device holds the line low after release, the high count does not run. The next pull follows (`cfg_high`+1)·(P+1)+4 kernel clocks after the line is let go.
- R9: Configuration changes made during a bit do not affect that bit. They take effect from the next bit.
- R10: `data_bit` is sampled only at the SDA update point. Later changes within the bit leave `sda_pull` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| cfg_presc | input | PW (4) | Prescale: one unit = value+1 kernel clocks |
| cfg_low | input | CW (8) | Clock low count, value+1 units |
| cfg_high | input | CW (8) | Clock high count, value+1 units |
| cfg_hold | input | DW (4) | Data hold delay in units after clock falls |
| cfg_setup | input | DW (4) | Data setup delay, value+1 units before release |
| scl_in | input | 1 | Sampled clock line level (asynchronous) |
| data_bit | input | 1 | Next bit to place on the data line |
| scl_pull | output | 1 | Clock open-drain enable (1 = pull low) |
| sda_pull | output | 1 | Data open-drain enable (1 = pull low) |
| bit_done | output | 1 | One-cycle strobe at the end of each bit |

## Verification
The assertions treat `scl_in` as a wired-AND line. It must read low whenever the block pulls it, two synchronizer clocks later. After release, other devices may hold it low only until it first goes high, and not again before bit-done. The bench models the bus exactly this way: the line is the inverse of `scl_pull` ANDed with a stretch signal. The stretch is raised only in the cycle the release is observed and is dropped once. Configuration inputs change only between bits or at the mid-bit point used for the R9 case. This keeps the captured values known when the bench computes its expected durations.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULL,
        ST_HOLD,
        ST_SETUP,
        ST_LOWREST,
        ST_RELEASE,
        ST_HIGH
    } pace_state_t;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Idle bus level is high, so the chain resets to ones.
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scl_unit_timer.sv
module scl_unit_timer #(
    parameter int PW = 4,
    parameter int UW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          start,
    input  logic [PW-1:0] presc,
    input  logic [UW-1:0] units,
    output logic          expired
);
    // Counts units*(presc+1) clocks after start, then holds expired until
    // the next start or clear. Zero units expires on the start edge itself.
    logic [PW-1:0] pre_q;
    logic [UW-1:0] left_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            left_q  <= '0;
            busy_q  <= 1'b0;
            expired <= 1'b0;
        end else if (clear) begin
            pre_q   <= '0;
            left_q  <= '0;
            busy_q  <= 1'b0;
            expired <= 1'b0;
        end else if (start) begin
            pre_q <= '0;
            if (units == '0) begin
                busy_q  <= 1'b0;
                expired <= 1'b1;
            end else begin
                busy_q  <= 1'b1;
                expired <= 1'b0;
                left_q  <= units;
            end
        end else if (busy_q) begin
            if (pre_q == presc) begin
                pre_q  <= '0;
                left_q <= left_q - 1'b1;
                if (left_q == UW'(1)) begin
                    busy_q  <= 1'b0;
                    expired <= 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
    parameter int PW          = 4,
    parameter int CW          = 8,
    parameter int DW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] cfg_presc,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_high,
    input  logic [DW-1:0] cfg_hold,
    input  logic [DW-1:0] cfg_setup,
    input  logic          scl_in,
    input  logic          data_bit,
    output logic          scl_pull,
    output logic          sda_pull,
    output logic          bit_done
);
    import scl_pacer_pkg::*;

    localparam int UW = ((CW > DW) ? CW : DW) + 1;

    pace_state_t   state_q, state_d;
    logic          scl_s;
    logic [PW-1:0] presc_q;
    logic [CW-1:0] low_q, high_q;
    logic [DW-1:0] hold_q, setup_q;
    logic          sda_q;

    logic          ck_start, ck_exp;
    logic [UW-1:0] ck_units;
    logic          dt_start, dt_exp;
    logic [UW-1:0] dt_units;
    logic          bit_start;

    scl_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (scl_in),
        .q     (scl_s)
    );

    // Clock-phase timer: low count, then high count.
    scl_unit_timer #(.PW(PW), .UW(UW)) ck_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!en),
        .start   (ck_start),
        .presc   (presc_q),
        .units   (ck_units),
        .expired (ck_exp)
    );

    // Data-path timer: hold delay, then setup delay.
    scl_unit_timer #(.PW(PW), .UW(UW)) dt_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!en),
        .start   (dt_start),
        .presc   (presc_q),
        .units   (dt_units),
        .expired (dt_exp)
    );

    always_comb begin
        ck_start = 1'b0;
        ck_units = '0;
        dt_start = 1'b0;
        dt_units = '0;
        if (state_q == ST_PULL && !scl_s) begin
            ck_start = 1'b1;
            ck_units = UW'(low_q) + UW'(1);
            dt_start = 1'b1;
            dt_units = UW'(hold_q);
        end else if (state_q == ST_HOLD && dt_exp) begin
            dt_start = 1'b1;
            dt_units = UW'(setup_q) + UW'(1);
        end else if (state_q == ST_RELEASE && scl_s) begin
            ck_start = 1'b1;
            ck_units = UW'(high_q) + UW'(1);
        end
    end

    assign bit_start = en && ((state_q == ST_IDLE) ||
                              (state_q == ST_HIGH && ck_exp));

    // Configuration is captured once per bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            low_q   <= '0;
            high_q  <= '0;
            hold_q  <= '0;
            setup_q <= '0;
        end else if (bit_start) begin
            presc_q <= cfg_presc;
            low_q   <= cfg_low;
            high_q  <= cfg_high;
            hold_q  <= cfg_hold;
            setup_q <= cfg_setup;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (en)     state_d = ST_PULL;
            ST_PULL:    if (!scl_s) state_d = ST_HOLD;
            ST_HOLD:    if (dt_exp) state_d = ST_SETUP;
            ST_SETUP:   if (dt_exp) state_d = ck_exp ? ST_RELEASE : ST_LOWREST;
            ST_LOWREST: if (ck_exp) state_d = ST_RELEASE;
            ST_RELEASE: if (scl_s)  state_d = ST_HIGH;
            ST_HIGH:    if (ck_exp) state_d = ST_PULL;
            default:                state_d = ST_IDLE;
        endcase
        if (!en) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Data drive register, updated only at the end of the hold delay.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          sda_q <= 1'b0;
        else if (!en)                        sda_q <= 1'b0;
        else if (state_q == ST_HOLD && dt_exp) sda_q <= !data_bit;
    end

    always_comb begin
        scl_pull = 1'b0;
        bit_done = 1'b0;
        unique case (state_q)
            ST_PULL, ST_HOLD, ST_SETUP, ST_LOWREST: scl_pull = 1'b1;
            ST_HIGH:                                bit_done = ck_exp;
            default:                                ;
        endcase
        sda_pull = sda_q;
    end
endmodule

// File: rtl/scl_pacer_chk.sv
module scl_pacer_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_pull,
    input logic sda_pull,
    input logic bit_done
);
    // R1: a low enable releases both lines on the next clock
    a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull && !sda_pull && !bit_done));

    // R6: the data drive only moves while the clock is pulled
    a_r6_sda_under_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (sda_pull != $past(sda_pull))) |-> $past(scl_pull));

    // R7: bit-done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |=> !bit_done);

    // R7: next bit follows bit-done at once
    a_r7_next_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_done && en) |=> scl_pull);

    // R8: a bit finishes only with the line high
    a_r8_done_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> scl_in);
endmodule

bind scl_pacer scl_pacer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .scl_in   (scl_in),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .bit_done (bit_done)
);

// File: tb/scl_pacer_tb_top.sv
module scl_pacer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] cfg_presc = '0;
    logic [7:0] cfg_low = '0;
    logic [7:0] cfg_high = '0;
    logic [3:0] cfg_hold = '0;
    logic [3:0] cfg_setup = '0;
    logic       data_bit = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_line;
    logic       scl_pull, sda_pull, bit_done;
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Wired-AND bus: pulled by the block or held by another device.
    assign scl_line = !(scl_pull || stretch);

    scl_pacer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cfg_presc (cfg_presc),
        .cfg_low   (cfg_low),
        .cfg_high  (cfg_high),
        .cfg_hold  (cfg_hold),
        .cfg_setup (cfg_setup),
        .scl_in    (scl_line),
        .data_bit  (data_bit),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .bit_done  (bit_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_cfg(input int p, input int l, input int h, input int d, input int s,
                           input int nbits, input int stretch_k, input int mid_h);
        cfg_presc = 4'(p);
        cfg_low   = 8'(l);
        cfg_high  = 8'(h);
        cfg_hold  = 4'(d);
        cfg_setup = 4'(s);
        data_bit  = 1'b0;
        en        = 1'b1;
        for (int b = 0; b < nbits; b++) begin
            int t0, t1, t2, tsda, ref_t, nchg, ndone, tdone;
            int ep, el, eh, ed, es, low_exp, low_data, hi_exp;
            logic prev_sda, exp_sda;
            while (!scl_pull) tick;
            t0 = cyc;
            ep = cfg_presc; el = cfg_low; eh = cfg_high; ed = cfg_hold; es = cfg_setup;
            data_bit = b[0];
            exp_sda  = !data_bit;
            prev_sda = sda_pull;
            nchg = 0; tsda = -1; ndone = 0; tdone = -1;
            while (scl_pull) begin
                tick;
                if (sda_pull != prev_sda) begin
                    nchg++;
                    if (tsda < 0) begin
                        tsda = cyc;
                        chk(sda_pull == exp_sda, "R4 sda value", int'(sda_pull), int'(exp_sda));
                        data_bit = !data_bit;  // R10: later change must be ignored
                        if (b == 1 && mid_h >= 0) cfg_high = 8'(mid_h);  // R9
                    end
                    prev_sda = sda_pull;
                end
            end
            t1 = cyc;
            chk(tsda - t0 == ed * (ep + 1) + 4, "R4 sda change point", tsda - t0, ed * (ep + 1) + 4);
            low_data = (ed + es + 1) * (ep + 1) + 5;
            low_exp  = imax((el + 1) * (ep + 1) + 4, low_data);
            if (low_data > (el + 1) * (ep + 1) + 4)
                chk(t1 - t0 == low_exp, "R5 low bounded by data path", t1 - t0, low_exp);
            else
                chk(t1 - t0 == low_exp, "R2 low duration", t1 - t0, low_exp);
            ref_t = t1;
            if (stretch_k > 0) begin
                stretch = 1'b1;
                for (int k = 0; k < stretch_k; k++) begin
                    tick;
                    if (bit_done || scl_pull) ndone += 100;
                end
                stretch = 1'b0;
                ref_t = cyc;
            end
            while (!scl_pull) begin
                if (bit_done) begin ndone++; tdone = cyc; end
                if (sda_pull != prev_sda) begin nchg++; prev_sda = sda_pull; end
                tick;
            end
            t2 = cyc;
            hi_exp = (eh + 1) * (ep + 1) + 4;
            if (stretch_k > 0)
                chk(t2 - ref_t == hi_exp, "R8 high after stretch", t2 - ref_t, hi_exp);
            else if (mid_h >= 0 && b >= 1)
                chk(t2 - ref_t == hi_exp, "R9 high uses captured config", t2 - ref_t, hi_exp);
            else
                chk(t2 - ref_t == hi_exp, "R3 high duration", t2 - ref_t, hi_exp);
            chk(ndone == 1 && tdone == t2 - 1, "R7 single bit_done before next pull", tdone, t2 - 1);
            chk(nchg == 1, "R6 sda moves once per bit", nchg, 1);
            chk(sda_pull == exp_sda, "R10 sda holds sampled bit", int'(sda_pull), int'(exp_sda));
        end
        en = 1'b0;
        tick;
        chk(!scl_pull && !sda_pull && !bit_done, "R1 release on disable",
            int'({scl_pull, sda_pull, bit_done}), 0);
        repeat (3) tick;
    endtask

    initial begin
        repeat (3) tick;
        chk(!scl_pull && !sda_pull && !bit_done, "R1 reset state",
            int'({scl_pull, sda_pull, bit_done}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick;
            chk(!scl_pull && !sda_pull, "R1 idle while disabled", int'({scl_pull, sda_pull}), 0);
        end

        run_cfg(1, 8'hC7, 8'hC3, 2, 4, 2, 0, -1);
        run_cfg(1, 8'h13, 8'h0F, 2, 4, 3, 7, -1);
        run_cfg(0, 9, 3, 1, 3, 3, 0, 6);
        run_cfg(0, 6, 3, 0, 1, 4, 3, -1);
        run_cfg(0, 2, 2, 3, 4, 3, 0, -1);
        run_cfg(15, 1, 0, 0, 0, 2, 0, -1);

        // R1: abort in the middle of a bit
        cfg_presc = 4'd1; cfg_low = 8'd20; cfg_high = 8'd5; cfg_hold = 4'd2; cfg_setup = 4'd2;
        data_bit = 1'b0;
        en = 1'b1;
        while (!scl_pull) tick;
        repeat (12) tick;
        en = 1'b0;
        tick;
        chk(!scl_pull && !sda_pull && !bit_done, "R1 abort mid-bit",
            int'({scl_pull, sda_pull, bit_done}), 0);
        repeat (4) tick;

        // Sweep of prescale, hold and setup around a short low count.
        for (int p = 0; p < 3; p++)
            for (int d = 0; d < 4; d++)
                for (int s = 0; s < 3; s++)
                    run_cfg(p, 3, 1, d, s, 2, (d == 1) ? 2 : 0, -1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule